// File: doc/BRIEF.md
# Binary Divider Chain with Split Test Mode

This block is a 24-stage binary ripple divider rebuilt as a synchronous design. A slow input clock (`tick_in`) is sampled by the fast system clock; every falling edge of that input advances the chain by one. Each stage halves the rate of the one below it, so the chain can absorb 16,777,216 input pulses before it wraps. Only the seven most significant stages (divide-by-2^18 up to divide-by-2^24) leave the block as tap outputs; the whole 24-bit state is also driven out for verification.

An active-high clear forces every stage to zero, whatever the mode, and while it is held it drops an oscillator-enable output so an upstream oscillator can be stopped to save standby power. A test-mode input cuts the chain into three 8-bit sections that all step on the same input edge, so from a cleared state 255 pulses fill every stage with ones; after returning to series mode a single pulse then exercises the full ripple from all ones to all zeros.

Top module: `bindiv_chain`

## Requirements
- R1: While `clr` is high every stage is zero (clearing is asynchronous); after `clr` is released the count stays zero until the next detected falling edge of `tick_in`.
- R2: `osc_en` is 0 whenever `clr` is high and returns to 1 within four system clock cycles after `clr` falls.
- R3: In series mode (`test_mode` = 0) each falling edge of `tick_in` raises `count` by exactly one; rising edges and steady input leave it unchanged.
- R4: `taps[k]` equals stage 18+k, i.e. `count[17+k]`, for k = 0..6; `taps[6]` is the divide-by-2^24 output.
- R5: In series mode, one falling edge from the all-ones state wraps `count` to zero.
- R6: In test mode (`test_mode` = 1) the sections `count[7:0]`, `count[15:8]` and `count[23:16]` each increase by one modulo 256 on every falling edge, with no carry between sections.
- R7: Starting from a cleared chain, 255 falling edges in test mode leave all 24 stages at 1.
- R8: Changing `test_mode` does not alter the stored count; the new partitioning applies from the next detected falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the divider input |
| clr | input | 1 | Active-high clear, asynchronous assert, synchronous release |
| tick_in | input | 1 | Slow input clock; its falling edges are counted |
| test_mode | input | 1 | 1 = three parallel 8-bit sections, 0 = one 24-bit series chain |
| osc_en | output | 1 | Oscillator enable, low during clear |
| taps | output | 7 | Stages 18 through 24 of the chain |
| count | output | 24 | Full chain state, for verification |

## Verification
On every cycle the assertions check that the count never moves without a detected falling edge, that a series-mode step is exactly plus one, that a test-mode step adds one to each section independently, and that clear holds both the count and the oscillator enable low. The bench's scenarios are needed to show the long-range behaviour: the 255-pulse fill to all ones, the full-chain rollover back to zero, the tap mapping on loaded patterns, and that toggling the mode leaves a known count untouched before the next pulse.

// File: rtl/bindiv_pkg.sv
package bindiv_pkg;
   typedef enum logic {
      MODE_SERIES = 1'b0,
      MODE_SPLIT  = 1'b1
   } chain_mode_e;

   localparam int unsigned DEF_STAGES  = 24;
   localparam int unsigned DEF_SECTION = 8;
   localparam int unsigned DEF_TAPS    = 7;
   localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/bindiv_rst_sync.sv
module bindiv_rst_sync #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_q
);
   logic [DEPTH-1:0] hold_r;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) hold_r <= '1;
      else      hold_r <= {hold_r[DEPTH-2:0], 1'b0};
   end

   assign rst_q = hold_r[DEPTH-1];
endmodule

// File: rtl/bindiv_edge_det.sv
module bindiv_edge_det #(
   parameter int unsigned SYNC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic fall
);
   logic [SYNC-1:0] sync_r;
   logic            prev_r;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sync_r <= '0;
         prev_r <= 1'b0;
      end else begin
         sync_r <= {sync_r[SYNC-2:0], din};
         prev_r <= sync_r[SYNC-1];
      end
   end

   assign fall = prev_r & ~sync_r[SYNC-1];
endmodule

// File: rtl/bindiv_section.sv
module bindiv_section #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cin,
   output logic [WIDTH-1:0] val,
   output logic             cout
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)      val <= '0;
      else if (cin) val <= val + 1'b1;
   end

   assign cout = cin & (&val);
endmodule

// File: rtl/bindiv_chain.sv
module bindiv_chain
   import bindiv_pkg::*;
#(
   parameter int unsigned STAGES  = DEF_STAGES,
   parameter int unsigned SECTION = DEF_SECTION,
   parameter int unsigned TAPS    = DEF_TAPS,
   parameter int unsigned SYNC    = DEF_SYNC
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              tick_in,
   input  logic              test_mode,
   output logic              osc_en,
   output logic [TAPS-1:0]   taps,
   output logic [STAGES-1:0] count
);
   localparam int unsigned NSEC   = STAGES / SECTION;
   localparam int unsigned TAP_LO = STAGES - TAPS;

   if (STAGES % SECTION != 0) begin : g_bad_split
      $error("STAGES must be a multiple of SECTION");
   end
   if (TAPS == 0 || TAPS > STAGES) begin : g_bad_taps
      $error("TAPS must lie in 1..STAGES");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("SYNC needs at least two flops");
   end

   logic        rst_q;
   logic        fall_en;
   chain_mode_e mode;
   logic [NSEC-1:0] sec_cin;
   logic [NSEC-1:0] sec_cout;

   bindiv_rst_sync #(.DEPTH(SYNC)) rst_sync_i (
      .clk   (clk),
      .arst  (clr),
      .rst_q (rst_q)
   );

   bindiv_edge_det #(.SYNC(SYNC)) edge_i (
      .clk  (clk),
      .rst  (rst_q),
      .din  (tick_in),
      .fall (fall_en)
   );

   assign mode = test_mode ? MODE_SPLIT : MODE_SERIES;

   for (genvar k = 0; k < NSEC; k++) begin : g_sec
      if (k == 0) begin : g_first
         assign sec_cin[k] = fall_en;
      end else begin : g_rest
         assign sec_cin[k] = (mode == MODE_SPLIT) ? fall_en : sec_cout[k-1];
      end

      bindiv_section #(.WIDTH(SECTION)) sec_i (
         .clk  (clk),
         .rst  (rst_q),
         .cin  (sec_cin[k]),
         .val  (count[k*SECTION +: SECTION]),
         .cout (sec_cout[k])
      );
   end

   assign taps   = count[STAGES-1:TAP_LO];
   assign osc_en = ~rst_q;
endmodule

// File: rtl/bindiv_chain_chk.sv
module bindiv_chain_chk #(
   parameter int unsigned STAGES  = 24,
   parameter int unsigned SECTION = 8
) (
   input logic              clk,
   input logic              clr,
   input logic              test_mode,
   input logic              fall,
   input logic              osc_en,
   input logic [STAGES-1:0] count
);
   localparam int unsigned NSEC = STAGES / SECTION;

   function automatic logic [STAGES-1:0] split_step(input logic [STAGES-1:0] v);
      logic [STAGES-1:0] r;
      for (int i = 0; i < NSEC; i++) begin
         r[i*SECTION +: SECTION] = v[i*SECTION +: SECTION] + 1'b1;
      end
      return r;
   endfunction

   AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> (count == '0)); // R1

   AST_OSC_STANDBY: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> !osc_en); // R2

   AST_NO_SPURIOUS_STEP: assert property (@(posedge clk) disable iff (clr)
      !$past(fall) |-> $stable(count)); // R3

   AST_SERIES_PLUS_ONE: assert property (@(posedge clk) disable iff (clr)
      ($past(fall) && !$past(test_mode)) |-> (count == $past(count) + 1'b1)); // R3

   AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (clr)
      ($past(fall) && $past(test_mode)) |-> (count == split_step($past(count)))); // R6
endmodule

bind bindiv_chain bindiv_chain_chk #(.STAGES(STAGES), .SECTION(SECTION)) chk_i (
   .clk       (clk),
   .clr       (clr),
   .test_mode (test_mode),
   .fall      (fall_en),
   .osc_en    (osc_en),
   .count     (count)
);

// File: tb/bindiv_chain_tb_top.sv
module bindiv_chain_tb_top;
   logic        clk = 1'b0;
   logic        clr = 1'b1;
   logic        tick_in = 1'b0;
   logic        test_mode = 1'b0;
   logic        osc_en;
   logic [6:0]  taps;
   logic [23:0] count;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   bindiv_chain dut_i (
      .clk       (clk),
      .clr       (clr),
      .tick_in   (tick_in),
      .test_mode (test_mode),
      .osc_en    (osc_en),
      .taps      (taps),
      .count     (count)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         tick_in = 1'b1; wait_n(4);
         tick_in = 1'b0; wait_n(4);
      end
   endtask

   task automatic do_clear();
      clr = 1'b1; wait_n(3);
      check("R1 clear count", count, 24'h0);
      check("R2 osc off in clear", {23'h0, osc_en}, 24'h1 ^ 24'h1);
      clr = 1'b0; wait_n(4);
      check("R2 osc on after release", {23'h0, osc_en}, 24'h1);
      check("R1 zero after release", count, 24'h0);
   endtask

   task automatic t_series();
      test_mode = 1'b0;
      do_clear();
      pulse(5);
      check("R3 five pulses", count, 24'd5);
      tick_in = 1'b1; wait_n(6);
      check("R3 rising edge ignored", count, 24'd5);
      tick_in = 1'b0; wait_n(4);
      check("R3 falling edge counts", count, 24'd6);
   endtask

   task automatic t_fill_and_roll();
      do_clear();
      test_mode = 1'b1;
      pulse(3);
      check("R6 split step x3", count, 24'h030303);
      check("R4 taps of 030303", {17'h0, taps}, 24'h1);
      pulse(252);
      check("R7 all ones after 255", count, 24'hFFFFFF);
      check("R4 taps all ones", {17'h0, taps}, 24'h7F);
      test_mode = 1'b0; wait_n(4);
      check("R8 mode exit keeps count", count, 24'hFFFFFF);
      pulse(1);
      check("R5 series rollover", count, 24'h0);
      check("R4 taps after rollover", {17'h0, taps}, 24'h0);
   endtask

   task automatic t_mode_switch();
      do_clear();
      test_mode = 1'b0;
      pulse(255);
      check("R3 series 255", count, 24'h0000FF);
      test_mode = 1'b1; wait_n(4);
      check("R8 mode entry keeps count", count, 24'h0000FF);
      pulse(1);
      check("R6 no carry between sections", count, 24'h010100);
      test_mode = 1'b0; wait_n(4);
      check("R8 back to series keeps count", count, 24'h010100);
      pulse(1);
      check("R3 series after split", count, 24'h010101);
      check("R4 taps of 010101", {17'h0, taps}, 24'h0);
   endtask

   task automatic t_clear_mid();
      test_mode = 1'b1;
      pulse(7);
      check("R6 split from 010101", count, 24'h080808);
      clr = 1'b1; wait_n(1);
      check("R1 async clear in split mode", count, 24'h0);
      check("R2 osc off mid run", {23'h0, osc_en}, 24'h0);
      do_clear();
   endtask

   initial begin
      wait_n(3);
      t_series();
      t_fill_and_roll();
      t_mode_switch();
      t_clear_mid();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule